// File: doc/BRIEF.md
# Two-Level Lookahead Adder, 16 Bits

This block adds two 16-bit operands and a carry-in without letting any carry ripple from one 4-bit slice to the next. Each of the four slices forms a per-bit generate (both bits set) and a per-bit propagate (bits differ). A lookahead network inside the slice turns these into the slice's internal carries as flat sum-of-products terms. The slice then forms each sum bit as propagate XOR incoming carry, and it reports a slice-wide propagate and generate.

A second lookahead network of the same shape takes the four slice propagate/generate pairs and the carry-in. From them it derives the carries into slices 1, 2 and 3, and it forms an adder-wide propagate and generate. The carry-out is built from that adder-wide pair. The adder-wide pair is brought out at the ports, so a wider adder can place this block under a further lookahead level. The block is purely combinational: it has no clock, no reset and no state.

Top module: `cla16_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i` for every input combination.
- R2: `cout_o` equals bit 16 of the 17-bit sum `a_i + b_i + cin_i`.
- R3: `grp_p_o` is 1 exactly when every bit of `a_i XOR b_i` is 1, and is independent of `cin_i`.
- R4: `grp_g_o` is 1 exactly when `a_i + b_i`, with no carry-in, overflows 16 bits; it is independent of `cin_i`.
- R5: `cout_o` equals `grp_g_o OR (grp_p_o AND cin_i)`, so the block can be placed under a further lookahead level.
- R6: The carry entering slice k (bit 4k, k = 1..3) equals the carry out of bits 4k-1..0 of the operands plus `cin_i`; it shows at `sum_o` bit 4k.
- R7: With all-ones and zero operands and `cin_i` = 1, the carry passes through all 16 positions: `sum_o` = 0, `cout_o` = 1, `grp_p_o` = 1, `grp_g_o` = 0.
- R8: The outputs are a pure function of the present inputs. No earlier input value affects them, and they are valid within the same cycle as the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Low 16 bits of the sum |
| cout_o | output | 1 | Carry out of bit 15 |
| grp_p_o | output | 1 | Adder-wide propagate |
| grp_g_o | output | 1 | Adder-wide generate |

## Verification
The hardest case to reach is a carry that must cross every slice boundary through propagate terms alone. That happens only when the operands differ in every bit. Random operands almost never meet that condition, since it holds for one operand pair in 65536. The stimulus therefore builds such pairs on purpose. It takes a random A with B = NOT A and runs both carry-in values. It also sends carries across single boundaries, using operands that propagate only in the low 4k bits. These sit alongside the fully random vectors.

// File: rtl/cla_pkg.sv
package cla_pkg;
    parameter int unsigned ADD_W   = 16;
    parameter int unsigned SLICE_W = 4;

    typedef struct packed {
        logic p;
        logic g;
    } pg_pair_t;
endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] p_i,
    input  logic [N-1:0] g_i,
    input  logic         c0_i,
    output logic [N-1:0] carry_o,
    output logic         gp_o,
    output logic         gg_o
);
    logic [N-1:0] carry_d;
    logic         gen_d;
    logic         term_d;
    logic         prod_d;

    // Flat sum-of-products per carry: no carry term feeds another
    always_comb begin
        carry_d    = '0;
        carry_d[0] = c0_i;
        gen_d      = 1'b0;
        term_d     = 1'b0;
        prod_d     = 1'b0;
        for (int i = 0; i < int'(N); i++) begin
            term_d = 1'b0;
            for (int j = 0; j <= i; j++) begin
                prod_d = g_i[j];
                for (int k = j + 1; k <= i; k++) begin
                    prod_d = prod_d & p_i[k];
                end
                term_d = term_d | prod_d;
            end
            gen_d  = term_d;
            prod_d = c0_i;
            for (int k = 0; k <= i; k++) begin
                prod_d = prod_d & p_i[k];
            end
            if (i + 1 < int'(N)) begin
                carry_d[i+1] = term_d | prod_d;
            end
        end
    end

    assign carry_o = carry_d;
    assign gg_o    = gen_d;
    assign gp_o    = &p_i;
endmodule

// File: rtl/cla_slice.sv
module cla_slice #(
    parameter int unsigned SW = 4
) (
    input  logic [SW-1:0] a_i,
    input  logic [SW-1:0] b_i,
    input  logic          cin_i,
    output logic [SW-1:0] sum_o,
    output logic          gp_o,
    output logic          gg_o
);
    logic [SW-1:0] bit_p;
    logic [SW-1:0] bit_g;
    logic [SW-1:0] bit_c;

    assign bit_p = a_i ^ b_i;
    assign bit_g = a_i & b_i;

    cla_lookahead #(.N(SW)) u_la (
        .p_i     (bit_p),
        .g_i     (bit_g),
        .c0_i    (cin_i),
        .carry_o (bit_c),
        .gp_o    (gp_o),
        .gg_o    (gg_o)
    );

    assign sum_o = bit_p ^ bit_c;
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla_pkg::*;
#(
    parameter int unsigned W  = ADD_W,
    parameter int unsigned SW = SLICE_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         grp_p_o,
    output logic         grp_g_o
);
    localparam int unsigned NS = W / SW;

    pg_pair_t [NS-1:0] slice_pg;
    logic     [NS-1:0] slice_p;
    logic     [NS-1:0] slice_g;
    logic     [NS-1:0] slice_c;

    for (genvar s = 0; s < NS; s++) begin : g_slice
        cla_slice #(.SW(SW)) u_slice (
            .a_i   (a_i[s*SW +: SW]),
            .b_i   (b_i[s*SW +: SW]),
            .cin_i (slice_c[s]),
            .sum_o (sum_o[s*SW +: SW]),
            .gp_o  (slice_pg[s].p),
            .gg_o  (slice_pg[s].g)
        );
        assign slice_p[s] = slice_pg[s].p;
        assign slice_g[s] = slice_pg[s].g;
    end

    cla_lookahead #(.N(NS)) u_top_la (
        .p_i     (slice_p),
        .g_i     (slice_g),
        .c0_i    (cin_i),
        .carry_o (slice_c),
        .gp_o    (grp_p_o),
        .gg_o    (grp_g_o)
    );

    assign cout_o = grp_g_o | (grp_p_o & cin_i);
endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk #(
    parameter int unsigned W  = 16,
    parameter int unsigned SW = 4
) (
    input logic [W-1:0]    a_i,
    input logic [W-1:0]    b_i,
    input logic            cin_i,
    input logic [W-1:0]    sum_o,
    input logic            cout_o,
    input logic            grp_p_o,
    input logic            grp_g_o,
    input logic [W/SW-1:0] slice_c
);
    localparam int unsigned NS = W / SW;

    logic [W:0] full_sum;
    logic [W:0] nocin_sum;

    assign full_sum  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    assign nocin_sum = {1'b0, a_i} + {1'b0, b_i};

    always_comb begin
        if (!$isunknown({a_i, b_i, cin_i})) begin
            a_r1_sum: assert (sum_o == full_sum[W-1:0]);
            a_r2_cout: assert (cout_o == full_sum[W]);
            a_r3_grp_prop: assert (grp_p_o == &(a_i ^ b_i));
            a_r4_grp_gen: assert (grp_g_o == nocin_sum[W]);
            for (int k = 1; k < int'(NS); k++) begin
                // R6: carry into slice k against the arithmetic low part
                a_r6_slice_carry: assert (slice_c[k] ==
                    (((({1'b0, a_i} & ((33'd1 << (k*SW)) - 1)) +
                       ({1'b0, b_i} & ((33'd1 << (k*SW)) - 1)) +
                       {{W{1'b0}}, cin_i}) >> (k*SW)) & 1) != 0);
            end
        end
    end
endmodule

bind cla16_adder cla16_adder_chk #(.W(W), .SW(SW)) u_chk (
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin_i),
    .sum_o   (sum_o),
    .cout_o  (cout_o),
    .grp_p_o (grp_p_o),
    .grp_g_o (grp_g_o),
    .slice_c (slice_c)
);

// File: tb/tb_cla16_adder.sv
module tb_cla16_adder;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic [W-1:0] a, b, sum;
    logic         cin, cout, gp, gg;
    int           n_vec  = 0;
    int           n_fail = 0;
    bit           done   = 1'b0;

    always #4 clk = ~clk;

    cla16_adder dut (
        .a_i(a), .b_i(b), .cin_i(cin),
        .sum_o(sum), .cout_o(cout), .grp_p_o(gp), .grp_g_o(gg)
    );

    function automatic logic [W:0] exp_sum(logic [W-1:0] x, logic [W-1:0] y, logic c);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    endfunction

    function automatic logic exp_gp(logic [W-1:0] x, logic [W-1:0] y);
        return &(x ^ y);
    endfunction

    function automatic logic exp_gg(logic [W-1:0] x, logic [W-1:0] y);
        logic [W:0] t;
        t = {1'b0, x} + {1'b0, y};
        return t[W];
    endfunction

    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic c, input string tag);
        logic [W:0] e;
        @(negedge clk);
        a = x; b = y; cin = c;
        #1;
        e = exp_sum(x, y, c);
        n_vec++;
        if (sum !== e[W-1:0]) begin
            n_fail++;
            $display("FAIL %s R1 sum a=%h b=%h c=%b got %h exp %h", tag, x, y, c, sum, e[W-1:0]);
        end
        if (cout !== e[W]) begin
            n_fail++;
            $display("FAIL %s R2 cout a=%h b=%h c=%b got %b exp %b", tag, x, y, c, cout, e[W]);
        end
        if (gp !== exp_gp(x, y)) begin
            n_fail++;
            $display("FAIL %s R3 grp_p a=%h b=%h got %b exp %b", tag, x, y, gp, exp_gp(x, y));
        end
        if (gg !== exp_gg(x, y)) begin
            n_fail++;
            $display("FAIL %s R4 grp_g a=%h b=%h got %b exp %b", tag, x, y, gg, exp_gg(x, y));
        end
        if (cout !== (gg | (gp & c))) begin
            n_fail++;
            $display("FAIL %s R5 cascade got %b exp %b", tag, cout, gg | (gp & c));
        end
    endtask

    initial begin
        logic [W-1:0] r;
        void'($urandom(32'd1357));
        a = '0; b = '0; cin = 1'b0;
        // R8: idle all-zero inputs give all-zero outputs
        apply(16'h0000, 16'h0000, 1'b0, "R8_zero");
        // R7: longest propagate chain
        apply(16'hFFFF, 16'h0000, 1'b1, "R7_chain");
        apply(16'h0000, 16'hFFFF, 1'b1, "R7_chain_swap");
        apply(16'hFFFF, 16'h0001, 1'b0, "R7_gen_low");
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R7_all_ones");
        // R6: carries entering each slice boundary
        apply(16'h000F, 16'h0001, 1'b0, "R6_into_s1");
        apply(16'h00FF, 16'h0000, 1'b1, "R6_into_s2");
        apply(16'h0FFF, 16'h0001, 1'b0, "R6_into_s3");
        apply(16'h0F0F, 16'h00F1, 1'b0, "R6_mixed");
        // R8: same operands after a different history give the same result
        apply(16'h1234, 16'h4321, 1'b1, "R8_hist_a");
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R8_between");
        apply(16'h1234, 16'h4321, 1'b1, "R8_hist_b");
        // R3/R5: full-propagate pairs B = ~A, both carry-ins
        for (int i = 0; i < 200; i++) begin
            r = W'($urandom);
            apply(r, ~r, 1'b0, "R3_prop_c0");
            apply(r, ~r, 1'b1, "R5_prop_c1");
        end
        // R6: propagate only in the low part, then random high bits
        for (int k = 1; k < 4; k++) begin
            for (int i = 0; i < 50; i++) begin
                r = W'($urandom);
                apply(r, (~r & W'((1 << (4*k)) - 1)) | (W'($urandom) & ~W'((1 << (4*k)) - 1)),
                      1'b1, "R6_boundary");
            end
        end
        // R1/R2/R4: random operands
        for (int i = 0; i < 3000; i++) begin
            apply(W'($urandom), W'($urandom), 1'($urandom), "R1_random");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired got running exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule